// File: doc/BRIEF.md
# Set-Associative Branch Target Buffer

This block sits beside the decode stage of a pipelined processor and remembers where recently taken branches went. Decode presents the fetch address of a branch on the lookup port. One cycle later the block reports three things: whether it holds an entry for that address, whether it predicts the branch taken, and the address to fetch next. That address is the stored target for a predicted-taken branch, or the sequential address otherwise.

Execute reports every resolved branch on the resolve port. The report carries the branch address, the actual direction, the actual target, a mispredict flag, and which of the two issue pipes held the branch.
- A branch that has an entry has its 2-bit saturating history moved one step toward the actual outcome, and its target refreshed when taken.
- A branch with no entry gets one only when it resolves taken. The new entry starts strongly taken.
- A mispredict raises a registered flush request. The request carries the restart address and the refill penalty of the pipe that held the branch.

The storage is 64 sets of 4 ways, 256 entries in all. Within a full set, the way to replace is chosen by a round-robin pointer kept for each set. A lookup and an update that reach the same set in the same cycle are ordered so that the lookup sees the update.

Top module: `btb_predictor`

## Requirements
- R1: A lookup is answered one clock later. `pred_valid` follows `lk_valid` by one cycle. When `pred_valid` is 0, `pred_hit` and `pred_taken` are 0.
- R2: A lookup with no matching valid entry reports `pred_hit`=0 and `pred_taken`=0, with `pred_next_pc` = `lk_pc` + 4. This holds whatever kind of branch it is.
- R3: On a hit, the 2-bit history decides the direction. Encodings 11 (strong taken) and 10 (weak taken) predict taken, with `pred_next_pc` = the stored target. Encodings 01 (weak not taken) and 00 (strong not taken) predict not taken, with `pred_next_pc` = `lk_pc` + 4.
- R4: A resolved branch that misses and is taken allocates an entry. The entry holds the resolved target and history 11, so the next lookup of that address hits and predicts taken.
- R5: A resolved branch that misses and is not taken allocates nothing, so a later lookup of that address still misses.
- R6: On a hit, a taken outcome raises the history by one step and a not-taken outcome lowers it by one step. The history saturates at 11 and at 00.
- R7: On a hit with a taken outcome, the stored target is replaced by the resolved target.
- R8: Address bits [7:2] select one of 64 sets and bits [31:8] form the tag. Four branches with different tags in one set are all held at once, without disturbing other sets.
- R9: Allocation into a set fills an invalid way first. When all four ways are valid, a per-set round-robin pointer picks the way to replace. The pointer starts at way 0 after reset and advances by one, wrapping, on each replacement. As a result, the fifth and sixth new tags in a fresh set evict the first and second.
- R10: When a resolve and a lookup address the same set in the same cycle, the lookup result already reflects that update.
- R11: One cycle after a resolve with the mispredict flag set, `flush_req` is 1 for one cycle. `flush_pc` is then the resolved target if taken, or the branch address + 4 if not taken. `flush_penalty` is 3 when `rs_pipe`=0 (primary pipe) and 4 when `rs_pipe`=1 (secondary pipe). In every other cycle `flush_req` is 0.
- R12: Reset, synchronous and active high, invalidates every entry and clears all outputs, so every lookup after reset misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_pc | input | 32 | Fetch address of the branch to look up |
| rs_valid | input | 1 | Resolved branch reported this cycle |
| rs_pc | input | 32 | Address of the resolved branch |
| rs_taken | input | 1 | Actual direction, 1 = taken |
| rs_target | input | 32 | Actual target of the branch |
| rs_mispredict | input | 1 | The earlier prediction was wrong |
| rs_pipe | input | 1 | Issue pipe of the branch: 0 primary, 1 secondary |
| pred_valid | output | 1 | Lookup result valid |
| pred_hit | output | 1 | Lookup found a valid entry |
| pred_taken | output | 1 | Branch predicted taken |
| pred_next_pc | output | 32 | Predicted next fetch address |
| flush_req | output | 1 | Pipeline flush request |
| flush_pc | output | 32 | Restart address for the flush |
| flush_penalty | output | 3 | Refill cycles for the pipe that held the branch |

## Verification
Some rules can be judged from the ports alone, and the assertions check these on every cycle:
- the one-cycle lookup timing;
- that a miss never predicts taken, and that a branch not predicted taken gets the sequential next address;
- that a resolve seen by a lookup in the same cycle always produces a hit, with its target when predicted taken;
- the timing, restart address and penalty of the flush request.

The bench's scenarios cover the behaviour that depends on the history stored across many resolves:
- the exact walk of the saturating counter, including both saturation points;
- the absence of allocation for not-taken misses;
- the refresh of a target;
- the set and tag split;
- the round-robin eviction order inside a full set;
- the clearing of all entries by reset.

// File: rtl/btb_pkg.sv
package btb_pkg;

  typedef enum logic [1:0] {
    HIST_SNT = 2'b00,
    HIST_WNT = 2'b01,
    HIST_WT  = 2'b10,
    HIST_ST  = 2'b11
  } hist_t;

  // One saturating step of the 2-bit direction counter.
  function automatic logic [1:0] hist_next(input logic [1:0] h, input logic taken);
    if (taken) return (h == HIST_ST) ? h : h + 2'b01;
    else       return (h == HIST_SNT) ? h : h - 2'b01;
  endfunction

  function automatic logic hist_says_taken(input logic [1:0] h);
    return h[1];
  endfunction

endpackage

// File: rtl/btb_way.sv
// One way of the buffer: valid bits in flops (resettable), payload in
// arrays with no reset so they can map onto distributed RAM.
module btb_way #(
  parameter int IDX_W  = 6,
  parameter int TAG_W  = 24,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  w_idx,
  input  logic [TAG_W-1:0]  w_tag,
  input  logic [1:0]        w_hist,
  input  logic [ADDR_W-1:0] w_tgt,
  input  logic [IDX_W-1:0]  a_idx,
  output logic              a_valid,
  output logic [TAG_W-1:0]  a_tag,
  output logic [1:0]        a_hist,
  output logic [ADDR_W-1:0] a_tgt,
  input  logic [IDX_W-1:0]  b_idx,
  output logic              b_valid,
  output logic [TAG_W-1:0]  b_tag,
  output logic [1:0]        b_hist,
  output logic [ADDR_W-1:0] b_tgt
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0]  valid_q;
  logic [TAG_W-1:0]  tag_mem  [DEPTH];
  logic [1:0]        hist_mem [DEPTH];
  logic [ADDR_W-1:0] tgt_mem  [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) valid_q <= '0;
    else if (we) valid_q[w_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (we) begin
      tag_mem[w_idx]  <= w_tag;
      hist_mem[w_idx] <= w_hist;
      tgt_mem[w_idx]  <= w_tgt;
    end
  end

  assign a_valid = valid_q[a_idx];
  assign a_tag   = tag_mem[a_idx];
  assign a_hist  = hist_mem[a_idx];
  assign a_tgt   = tgt_mem[a_idx];

  assign b_valid = valid_q[b_idx];
  assign b_tag   = tag_mem[b_idx];
  assign b_hist  = hist_mem[b_idx];
  assign b_tgt   = tgt_mem[b_idx];

endmodule

// File: rtl/btb_match.sv
// Tag compare across all ways of a set; lowest matching way wins.
module btb_match #(
  parameter int NWAYS = 4,
  parameter int WAY_W = 2,
  parameter int TAG_W = 24
) (
  input  logic [NWAYS-1:0] valid,
  input  logic [TAG_W-1:0] tags [NWAYS],
  input  logic [TAG_W-1:0] key,
  output logic             hit,
  output logic [WAY_W-1:0] way
);
  logic [NWAYS-1:0] eq;

  for (genvar w = 0; w < NWAYS; w++) begin : g_cmp
    assign eq[w] = valid[w] && (tags[w] == key);
  end

  always_comb begin
    way = '0;
    for (int w = NWAYS - 1; w >= 0; w--) begin
      if (eq[w]) way = WAY_W'(w);
    end
  end

  assign hit = |eq;

endmodule

// File: rtl/btb_victim.sv
// Replacement choice: lowest invalid way, else the set's round-robin pointer.
module btb_victim #(
  parameter int NSETS = 64,
  parameter int NWAYS = 4,
  parameter int IDX_W = 6,
  parameter int WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] idx,
  input  logic [NWAYS-1:0] valid,
  input  logic             alloc,
  output logic [WAY_W-1:0] victim
);
  logic [WAY_W-1:0] ptr_q [NSETS];
  logic [WAY_W-1:0] first_free;
  logic             full;

  assign full = &valid;

  always_comb begin
    first_free = '0;
    for (int w = NWAYS - 1; w >= 0; w--) begin
      if (!valid[w]) first_free = WAY_W'(w);
    end
  end

  assign victim = full ? ptr_q[idx] : first_free;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NSETS; s++) ptr_q[s] <= '0;
    end else if (alloc && full) begin
      if (ptr_q[idx] == WAY_W'(NWAYS - 1)) ptr_q[idx] <= '0;
      else ptr_q[idx] <= ptr_q[idx] + 1'b1;
    end
  end

endmodule

// File: rtl/btb_predictor.sv
module btb_predictor #(
  parameter int ADDR_W     = 32,
  parameter int NSETS      = 64,
  parameter int NWAYS      = 4,
  parameter int OFF_W      = 2,
  parameter int INSN_BYTES = 4,
  parameter int PEN_W      = 3,
  parameter int PEN_PRI    = 3,
  parameter int PEN_SEC    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_pc,
  input  logic              rs_valid,
  input  logic [ADDR_W-1:0] rs_pc,
  input  logic              rs_taken,
  input  logic [ADDR_W-1:0] rs_target,
  input  logic              rs_mispredict,
  input  logic              rs_pipe,
  output logic              pred_valid,
  output logic              pred_hit,
  output logic              pred_taken,
  output logic [ADDR_W-1:0] pred_next_pc,
  output logic              flush_req,
  output logic [ADDR_W-1:0] flush_pc,
  output logic [PEN_W-1:0]  flush_penalty
);
  import btb_pkg::*;

  localparam int IDX_W = $clog2(NSETS);
  localparam int WAY_W = (NWAYS > 1) ? $clog2(NWAYS) : 1;
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
  localparam int IDX_LO = OFF_W;
  localparam int TAG_LO = OFF_W + IDX_W;

  // Address split
  logic [IDX_W-1:0] lk_idx, rs_idx;
  logic [TAG_W-1:0] lk_tag, rs_tag;
  assign lk_idx = lk_pc[TAG_LO-1:IDX_LO];
  assign lk_tag = lk_pc[ADDR_W-1:TAG_LO];
  assign rs_idx = rs_pc[TAG_LO-1:IDX_LO];
  assign rs_tag = rs_pc[ADDR_W-1:TAG_LO];

  // Per-way read data: resolve side (a) and lookup side (b)
  logic [NWAYS-1:0] rd_v;
  logic [TAG_W-1:0] rd_tag [NWAYS];
  logic [1:0]       rd_hist [NWAYS];
  logic [ADDR_W-1:0] rd_tgt [NWAYS];
  logic [NWAYS-1:0] lr_v;
  logic [TAG_W-1:0] lr_tag [NWAYS];
  logic [1:0]       lr_hist [NWAYS];
  logic [ADDR_W-1:0] lr_tgt [NWAYS];

  // Update path
  logic              u_hit;
  logic [WAY_W-1:0]  u_way;
  logic [WAY_W-1:0]  victim;
  logic              alloc;
  logic              wr_en;
  logic [WAY_W-1:0]  wr_way;
  logic [1:0]        wr_hist;
  logic [ADDR_W-1:0] wr_tgt;
  logic [NWAYS-1:0]  way_we;

  btb_match #(.NWAYS(NWAYS), .WAY_W(WAY_W), .TAG_W(TAG_W)) u_rs_match (
    .valid(rd_v), .tags(rd_tag), .key(rs_tag), .hit(u_hit), .way(u_way)
  );

  assign alloc = rs_valid && !u_hit && rs_taken;

  btb_victim #(.NSETS(NSETS), .NWAYS(NWAYS), .IDX_W(IDX_W), .WAY_W(WAY_W)) u_victim (
    .clk(clk), .rst(rst), .idx(rs_idx), .valid(rd_v), .alloc(alloc), .victim(victim)
  );

  always_comb begin
    wr_en   = rs_valid && (u_hit || rs_taken);
    wr_way  = u_hit ? u_way : victim;
    wr_hist = u_hit ? hist_next(rd_hist[u_way], rs_taken) : HIST_ST;
    wr_tgt  = (u_hit && !rs_taken) ? rd_tgt[u_way] : rs_target;
  end

  for (genvar w = 0; w < NWAYS; w++) begin : g_way
    assign way_we[w] = wr_en && (wr_way == WAY_W'(w));

    btb_way #(.IDX_W(IDX_W), .TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_way (
      .clk(clk), .rst(rst), .we(way_we[w]),
      .w_idx(rs_idx), .w_tag(rs_tag), .w_hist(wr_hist), .w_tgt(wr_tgt),
      .a_idx(rs_idx), .a_valid(rd_v[w]), .a_tag(rd_tag[w]),
      .a_hist(rd_hist[w]), .a_tgt(rd_tgt[w]),
      .b_idx(lk_idx), .b_valid(lr_v[w]), .b_tag(lr_tag[w]),
      .b_hist(lr_hist[w]), .b_tgt(lr_tgt[w])
    );
  end

  // Lookup path with same-cycle forwarding of the update
  logic [NWAYS-1:0]  lf_v;
  logic [TAG_W-1:0]  lf_tag [NWAYS];
  logic [1:0]        lf_hist [NWAYS];
  logic [ADDR_W-1:0] lf_tgt [NWAYS];
  logic              l_hit;
  logic [WAY_W-1:0]  l_way;
  logic              l_taken;

  for (genvar w = 0; w < NWAYS; w++) begin : g_fwd
    logic sel;
    assign sel        = way_we[w] && (rs_idx == lk_idx);
    assign lf_v[w]    = sel ? 1'b1    : lr_v[w];
    assign lf_tag[w]  = sel ? rs_tag  : lr_tag[w];
    assign lf_hist[w] = sel ? wr_hist : lr_hist[w];
    assign lf_tgt[w]  = sel ? wr_tgt  : lr_tgt[w];
  end

  btb_match #(.NWAYS(NWAYS), .WAY_W(WAY_W), .TAG_W(TAG_W)) u_lk_match (
    .valid(lf_v), .tags(lf_tag), .key(lk_tag), .hit(l_hit), .way(l_way)
  );

  assign l_taken = l_hit && hist_says_taken(lf_hist[l_way]);

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_valid   <= 1'b0;
      pred_hit     <= 1'b0;
      pred_taken   <= 1'b0;
      pred_next_pc <= '0;
    end else begin
      pred_valid   <= lk_valid;
      pred_hit     <= lk_valid && l_hit;
      pred_taken   <= lk_valid && l_taken;
      pred_next_pc <= (lk_valid && l_taken) ? lf_tgt[l_way]
                                            : lk_pc + ADDR_W'(INSN_BYTES);
    end
  end

  // Flush request
  always_ff @(posedge clk) begin
    if (rst) begin
      flush_req     <= 1'b0;
      flush_pc      <= '0;
      flush_penalty <= '0;
    end else begin
      flush_req     <= rs_valid && rs_mispredict;
      flush_pc      <= rs_taken ? rs_target : rs_pc + ADDR_W'(INSN_BYTES);
      flush_penalty <= rs_pipe ? PEN_W'(PEN_SEC) : PEN_W'(PEN_PRI);
    end
  end

endmodule

// File: rtl/btb_predictor_chk.sv
module btb_predictor_chk #(
  parameter int ADDR_W     = 32,
  parameter int INSN_BYTES = 4,
  parameter int PEN_W      = 3,
  parameter int PEN_PRI    = 3,
  parameter int PEN_SEC    = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              lk_valid,
  input logic [ADDR_W-1:0] lk_pc,
  input logic              rs_valid,
  input logic [ADDR_W-1:0] rs_pc,
  input logic              rs_taken,
  input logic [ADDR_W-1:0] rs_target,
  input logic              rs_mispredict,
  input logic              rs_pipe,
  input logic              pred_valid,
  input logic              pred_hit,
  input logic              pred_taken,
  input logic [ADDR_W-1:0] pred_next_pc,
  input logic              flush_req,
  input logic [ADDR_W-1:0] flush_pc,
  input logic [PEN_W-1:0]  flush_penalty
);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !pred_valid |-> (!pred_hit && !pred_taken));

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> pred_valid);

  assert_valid_drops_R1: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !pred_valid);

  assert_miss_not_taken_R2: assert property (@(posedge clk) disable iff (rst)
    (pred_valid && !pred_hit) |-> !pred_taken);

  assert_seq_next_R2: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> (pred_taken || pred_next_pc == $past(lk_pc) + ADDR_W'(INSN_BYTES)));

  assert_taken_needs_hit_R3: assert property (@(posedge clk) disable iff (rst)
    pred_taken |-> pred_hit);

  assert_same_cycle_seen_R10: assert property (@(posedge clk) disable iff (rst)
    (rs_valid && rs_taken && lk_valid && lk_pc == rs_pc)
      |=> (pred_hit && (!pred_taken || pred_next_pc == $past(rs_target))));

  assert_flush_raise_R11: assert property (@(posedge clk) disable iff (rst)
    (rs_valid && rs_mispredict) |=> flush_req);

  assert_flush_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    !(rs_valid && rs_mispredict) |=> !flush_req);

  assert_flush_pc_R11: assert property (@(posedge clk) disable iff (rst)
    (rs_valid && rs_mispredict) |=>
      (flush_pc == ($past(rs_taken) ? $past(rs_target)
                                    : $past(rs_pc) + ADDR_W'(INSN_BYTES))));

  assert_flush_cost_R11: assert property (@(posedge clk) disable iff (rst)
    (rs_valid && rs_mispredict) |=>
      (flush_penalty == ($past(rs_pipe) ? PEN_W'(PEN_SEC) : PEN_W'(PEN_PRI))));

endmodule

bind btb_predictor btb_predictor_chk #(
  .ADDR_W(ADDR_W), .INSN_BYTES(INSN_BYTES), .PEN_W(PEN_W),
  .PEN_PRI(PEN_PRI), .PEN_SEC(PEN_SEC)
) u_chk (
  .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_pc(lk_pc),
  .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_taken(rs_taken),
  .rs_target(rs_target), .rs_mispredict(rs_mispredict), .rs_pipe(rs_pipe),
  .pred_valid(pred_valid), .pred_hit(pred_hit), .pred_taken(pred_taken),
  .pred_next_pc(pred_next_pc), .flush_req(flush_req), .flush_pc(flush_pc),
  .flush_penalty(flush_penalty)
);

// File: tb/btb_predictor_bench.sv
`timescale 1ns/1ps
module btb_predictor_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_pc = '0;
  logic        rs_valid = 1'b0;
  logic [31:0] rs_pc = '0;
  logic        rs_taken = 1'b0;
  logic [31:0] rs_target = '0;
  logic        rs_mispredict = 1'b0;
  logic        rs_pipe = 1'b0;
  logic        pred_valid, pred_hit, pred_taken;
  logic [31:0] pred_next_pc;
  logic        flush_req;
  logic [31:0] flush_pc;
  logic [2:0]  flush_penalty;

  int vectors = 0;
  int miscompares = 0;

  always #4 clk = ~clk;

  btb_predictor u_btb_predictor (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_pc(lk_pc),
    .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_taken(rs_taken),
    .rs_target(rs_target), .rs_mispredict(rs_mispredict), .rs_pipe(rs_pipe),
    .pred_valid(pred_valid), .pred_hit(pred_hit), .pred_taken(pred_taken),
    .pred_next_pc(pred_next_pc), .flush_req(flush_req), .flush_pc(flush_pc),
    .flush_penalty(flush_penalty)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Lookup: drive at a falling edge, sample at the next falling edge.
  task automatic expect_lookup(input logic [31:0] pc, input logic hit,
                               input logic taken, input logic [31:0] npc,
                               input string req);
    @(negedge clk);
    lk_valid = 1'b1;
    lk_pc = pc;
    @(negedge clk);
    check(req, "pred_valid", {31'd0, pred_valid}, 32'd1);
    check(req, "pred_hit", {31'd0, pred_hit}, {31'd0, hit});
    check(req, "pred_taken", {31'd0, pred_taken}, {31'd0, taken});
    check(req, "pred_next_pc", pred_next_pc, npc);
    lk_valid = 1'b0;
  endtask

  task automatic resolve(input logic [31:0] pc, input logic taken,
                         input logic [31:0] tgt, input logic mis,
                         input logic pipe);
    @(negedge clk);
    rs_valid = 1'b1;
    rs_pc = pc;
    rs_taken = taken;
    rs_target = tgt;
    rs_mispredict = mis;
    rs_pipe = pipe;
    @(negedge clk);
    rs_valid = 1'b0;
    rs_mispredict = 1'b0;
  endtask

  task automatic t_reset();
    check("R12", "pred_valid after reset", {31'd0, pred_valid}, 32'd0);
    check("R12", "pred_hit after reset", {31'd0, pred_hit}, 32'd0);
    check("R12", "flush_req after reset", {31'd0, flush_req}, 32'd0);
    check("R12", "pred_next_pc after reset", pred_next_pc, 32'd0);
    expect_lookup(32'h0000_0100, 1'b0, 1'b0, 32'h0000_0104, "R2");
  endtask

  task automatic t_alloc();
    resolve(32'h0000_1000, 1'b0, 32'h0000_2000, 1'b0, 1'b0);
    expect_lookup(32'h0000_1000, 1'b0, 1'b0, 32'h0000_1004, "R5");
    resolve(32'h0000_1000, 1'b1, 32'h0000_2000, 1'b1, 1'b0);
    expect_lookup(32'h0000_1000, 1'b1, 1'b1, 32'h0000_2000, "R4");
  endtask

  task automatic t_idle();
    @(negedge clk);
    lk_valid = 1'b0;
    lk_pc = 32'h0000_1000;
    @(negedge clk);
    check("R1", "pred_valid idle", {31'd0, pred_valid}, 32'd0);
    check("R1", "pred_hit idle", {31'd0, pred_hit}, 32'd0);
    check("R1", "pred_taken idle", {31'd0, pred_taken}, 32'd0);
  endtask

  // History starts at 11 after t_alloc.
  task automatic t_counter();
    resolve(32'h0000_1000, 1'b0, 32'h0, 1'b0, 1'b0); // 10
    expect_lookup(32'h0000_1000, 1'b1, 1'b1, 32'h0000_2000, "R3 weak taken");
    resolve(32'h0000_1000, 1'b0, 32'h0, 1'b0, 1'b0); // 01
    expect_lookup(32'h0000_1000, 1'b1, 1'b0, 32'h0000_1004, "R3 weak not taken");
    resolve(32'h0000_1000, 1'b0, 32'h0, 1'b0, 1'b0); // 00
    resolve(32'h0000_1000, 1'b0, 32'h0, 1'b0, 1'b0); // 00 saturated
    resolve(32'h0000_1000, 1'b1, 32'h0000_2000, 1'b0, 1'b0); // 01
    expect_lookup(32'h0000_1000, 1'b1, 1'b0, 32'h0000_1004, "R6 low saturation");
    resolve(32'h0000_1000, 1'b1, 32'h0000_2000, 1'b0, 1'b0); // 10
    expect_lookup(32'h0000_1000, 1'b1, 1'b1, 32'h0000_2000, "R6 step up");
    resolve(32'h0000_1000, 1'b1, 32'h0000_2000, 1'b0, 1'b0); // 11
    resolve(32'h0000_1000, 1'b1, 32'h0000_2000, 1'b0, 1'b0); // 11 saturated
    resolve(32'h0000_1000, 1'b0, 32'h0, 1'b0, 1'b0); // 10
    expect_lookup(32'h0000_1000, 1'b1, 1'b1, 32'h0000_2000, "R6 high saturation");
    resolve(32'h0000_1000, 1'b0, 32'h0, 1'b0, 1'b0); // 01
    expect_lookup(32'h0000_1000, 1'b1, 1'b0, 32'h0000_1004, "R6 step down");
  endtask

  task automatic t_target();
    resolve(32'h0000_1000, 1'b1, 32'h0000_3000, 1'b0, 1'b0); // 10, new target
    expect_lookup(32'h0000_1000, 1'b1, 1'b1, 32'h0000_3000, "R7");
  endtask

  // Set 5: tag n gives pc = n*0x100 + 0x14
  task automatic t_sets();
    for (int n = 0; n < 4; n++)
      resolve(32'h0000_5014 + 32'(n) * 32'h100, 1'b1, 32'h000A_0000 + 32'(n) * 32'h10, 1'b0, 1'b0);
    for (int n = 0; n < 4; n++)
      expect_lookup(32'h0000_5014 + 32'(n) * 32'h100, 1'b1, 1'b1,
                    32'h000A_0000 + 32'(n) * 32'h10, "R8 four ways held");
    expect_lookup(32'h0000_1000, 1'b1, 1'b1, 32'h0000_3000, "R8 other set intact");
    resolve(32'h0000_5414, 1'b1, 32'h000A_0040, 1'b0, 1'b0);
    expect_lookup(32'h0000_5014, 1'b0, 1'b0, 32'h0000_5018, "R9 first eviction");
    expect_lookup(32'h0000_5414, 1'b1, 1'b1, 32'h000A_0040, "R9 new entry");
    resolve(32'h0000_5514, 1'b1, 32'h000A_0050, 1'b0, 1'b0);
    expect_lookup(32'h0000_5114, 1'b0, 1'b0, 32'h0000_5118, "R9 second eviction");
    expect_lookup(32'h0000_5214, 1'b1, 1'b1, 32'h000A_0020, "R9 survivor");
    expect_lookup(32'h0000_5314, 1'b1, 1'b1, 32'h000A_0030, "R9 survivor");
    expect_lookup(32'h0000_5514, 1'b1, 1'b1, 32'h000A_0050, "R9 new entry");
  endtask

  task automatic t_collision();
    @(negedge clk);
    rs_valid = 1'b1; rs_pc = 32'h0000_6030; rs_taken = 1'b1;
    rs_target = 32'h0000_7770; rs_mispredict = 1'b0; rs_pipe = 1'b0;
    lk_valid = 1'b1; lk_pc = 32'h0000_6030;
    @(negedge clk);
    check("R10", "pred_hit same cycle", {31'd0, pred_hit}, 32'd1);
    check("R10", "pred_taken same cycle", {31'd0, pred_taken}, 32'd1);
    check("R10", "pred_next_pc same cycle", pred_next_pc, 32'h0000_7770);
    rs_valid = 1'b0; lk_valid = 1'b0;
  endtask

  task automatic t_flush();
    resolve(32'h0000_9000, 1'b1, 32'h0000_9400, 1'b1, 1'b0);
    check("R11", "flush_req taken", {31'd0, flush_req}, 32'd1);
    check("R11", "flush_pc taken", flush_pc, 32'h0000_9400);
    check("R11", "penalty primary", {29'd0, flush_penalty}, 32'd3);
    @(negedge clk);
    check("R11", "flush_req single cycle", {31'd0, flush_req}, 32'd0);
    resolve(32'h0000_8000, 1'b0, 32'h0000_8800, 1'b1, 1'b1);
    check("R11", "flush_req not taken", {31'd0, flush_req}, 32'd1);
    check("R11", "flush_pc sequential", flush_pc, 32'h0000_8004);
    check("R11", "penalty secondary", {29'd0, flush_penalty}, 32'd4);
    resolve(32'h0000_8000, 1'b0, 32'h0, 1'b0, 1'b1);
    check("R11", "no flush when correct", {31'd0, flush_req}, 32'd0);
  endtask

  task automatic t_rereset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    expect_lookup(32'h0000_1000, 1'b0, 1'b0, 32'h0000_1004, "R12 entries cleared");
    expect_lookup(32'h0000_5514, 1'b0, 1'b0, 32'h0000_5518, "R12 entries cleared");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_alloc();
    t_idle();
    t_counter();
    t_target();
    t_sets();
    t_collision();
    t_flush();
    t_rereset();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule